// File: doc/BRIEF.md
# Burst Command Splitter for a Memory-Mapped Master

The block sits between user logic and a memory-mapped master port that has separate address, data and response channels with valid/ready handshakes. User logic supplies a single command: a start address, a transfer size in bytes and a direction. The block turns that command into a run of incrementing bursts. Each burst is no longer than a configured maximum beat count. The bursts go out one at a time: every full-size burst comes first, then one shorter burst for whatever remains. For example, with a 32-bit bus and a 16-beat limit, an 80-byte request becomes a 16-beat burst followed by a 4-beat burst.

On the user side, data moves through a streaming port in each direction. The block marks the first beat of the whole transfer with an active-low start marker and the last beat with an active-low end marker. These markers span burst boundaries, so user logic sees one continuous frame. A one-cycle acknowledge pulse tells user logic the command has been taken. A one-cycle completion pulse closes the command. An error flag travels with the completion pulse when any burst came back with a non-OKAY response.

The start address and the byte length must be whole multiples of the bus width in bytes, and the length must be nonzero. Only one burst is in flight at any time.

Top module: `burst_cmd_splitter`

## Requirements
- R1: In idle, a high `cmd_valid` is taken at the next clock edge. `cmd_ack` is then high for exactly the one following cycle.
- R2: A command of N beats, where N is the byte length divided by the bus width in bytes, is issued as bursts of min(remaining, MAX_BEATS) beats, largest first. The burst length field carries beats minus one.
- R3: The first burst uses the command address. Each later burst address is the previous address plus that burst's beat count times the bus width in bytes.
- R4: Every burst carries a size code of log2(bus bytes) (2 for a 32-bit bus) and burst type 2'b01 (incrementing). Write strobes are all ones.
- R5: Only one burst is outstanding. No address valid is raised until the previous write response, or the previous read beat flagged last, has been accepted. Data and response handshakes are only enabled in their own phase.
- R6: On writes, `wlast` is high on the final beat of each burst and on no other beat.
- R7: On both directions, the active-low start marker is low only on the first beat of the whole command. The active-low end marker is low only on the last beat of the whole command.
- R8: During a data phase, write valid, ready and data pass straight between the user stream and the master port. Read valid, ready and data pass the same way in the other direction.
- R9: `cmd_done` is high for one cycle. That cycle is the one right after the final write response is accepted, or right after the final read beat flagged last is accepted.
- R10: `cmd_err` is high with `cmd_done` if and only if any response code of the command was not 2'b00. The flag is cleared for each new command.
- R11: While reset is held, every valid, ready, acknowledge and completion output is low.
- R12: An address valid, once raised, stays high with unchanged address and length until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, held until acknowledged |
| cmd_addr | input | ADDR_W | Start address, bus-width aligned |
| cmd_len | input | LEN_W | Transfer size in bytes, bus-width multiple |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_ack | output | 1 | Command taken pulse |
| cmd_done | output | 1 | Command finished pulse |
| cmd_err | output | 1 | Error flag, valid with cmd_done |
| wr_data | input | DATA_W | User write data |
| wr_valid | input | 1 | User write data valid |
| wr_ready | output | 1 | Write beat taken |
| wr_sof_n | output | 1 | Low on first write beat of command |
| wr_eof_n | output | 1 | Low on last write beat of command |
| rd_data | output | DATA_W | Read data to user |
| rd_valid | output | 1 | Read data valid |
| rd_ready | input | 1 | User accepts read beat |
| rd_sof_n | output | 1 | Low on first read beat of command |
| rd_eof_n | output | 1 | Low on last read beat of command |
| awaddr | output | ADDR_W | Write burst address |
| awlen | output | 8 | Write burst beats minus one |
| awsize | output | 3 | Write beat size code |
| awburst | output | 2 | Write burst type |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write strobes |
| wlast | output | 1 | Last beat of write burst |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| araddr | output | ADDR_W | Read burst address |
| arlen | output | 8 | Read burst beats minus one |
| arsize | output | 3 | Read beat size code |
| arburst | output | 2 | Read burst type |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| rdata | input | DATA_W | Read data |
| rresp | input | 2 | Read response code |
| rlast | input | 1 | Last beat of read burst |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |

## Verification
Corrupted remaining-beat bookkeeping shows up at the first address handshake after the corruption, as a wrong burst length or a wrong address. Corrupted beat counters show up within one burst, as a misplaced `wlast` or a start or end marker on the wrong beat. A wrong phase or state shows up in the very next cycle, either as a valid or ready raised outside its phase, or as an early or missing `cmd_done` pulse. The bench sweeps every beat count up to five bursts in both directions against a slave whose stalls vary by cycle, so each burst remainder and each handshake order is seen.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_RESP,
        ST_DONE
    } bcs_state_e;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/bcs_chunker.sv
`timescale 1ns/1ps
// Sizes the next burst from the beats still unissued and steps the address.
module bcs_chunker #(
    parameter int ADDR_W    = 32,
    parameter int BEAT_W    = 14,
    parameter int CNT_W     = 5,
    parameter int MAX_BEATS = 16,
    parameter int SZ        = 2
) (
    input  logic [BEAT_W-1:0] remain,
    input  logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  cur,
    output logic [7:0]        axlen,
    output logic [ADDR_W-1:0] next_addr,
    output logic [BEAT_W-1:0] next_remain
);

    always_comb begin
        if (remain > BEAT_W'(MAX_BEATS)) begin
            cur = CNT_W'(MAX_BEATS);
        end else begin
            cur = CNT_W'(remain);
        end
        axlen       = 8'(cur - CNT_W'(1));
        next_addr   = addr + (ADDR_W'(cur) << SZ);
        next_remain = remain - BEAT_W'(cur);
    end

endmodule

// File: rtl/bcs_beat_track.sv
`timescale 1ns/1ps
// Counts beats left in the current burst and in the whole command.
module bcs_beat_track #(
    parameter int BEAT_W = 14,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_xfer,
    input  logic [BEAT_W-1:0] xfer_beats,
    input  logic              load_burst,
    input  logic [CNT_W-1:0]  burst_beats,
    input  logic              beat,
    output logic              burst_last,
    output logic              xfer_first,
    output logic              xfer_last
);

    typedef struct packed {
        logic [CNT_W-1:0]  burst_left;
        logic [BEAT_W-1:0] xfer_left;
        logic              first;
    } track_s;

    track_s trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (load_xfer) begin
            trk_d.xfer_left = xfer_beats;
            trk_d.first     = 1'b1;
        end
        if (load_burst) begin
            trk_d.burst_left = burst_beats;
        end
        if (beat) begin
            trk_d.burst_left = trk_q.burst_left - CNT_W'(1);
            trk_d.xfer_left  = trk_q.xfer_left - BEAT_W'(1);
            trk_d.first      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign burst_last = (trk_q.burst_left == CNT_W'(1));
    assign xfer_first = trk_q.first;
    assign xfer_last  = (trk_q.xfer_left == BEAT_W'(1));

endmodule

// File: rtl/burst_cmd_splitter.sv
`timescale 1ns/1ps
module burst_cmd_splitter #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MAX_BEATS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [LEN_W-1:0]      cmd_len,
    input  logic                  cmd_rnw,
    output logic                  cmd_ack,
    output logic                  cmd_done,
    output logic                  cmd_err,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  wr_valid,
    output logic                  wr_ready,
    output logic                  wr_sof_n,
    output logic                  wr_eof_n,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    input  logic                  rd_ready,
    output logic                  rd_sof_n,
    output logic                  rd_eof_n,
    output logic [ADDR_W-1:0]     awaddr,
    output logic [7:0]            awlen,
    output logic [2:0]            awsize,
    output logic [1:0]            awburst,
    output logic                  awvalid,
    input  logic                  awready,
    output logic [DATA_W-1:0]     wdata,
    output logic [DATA_W/8-1:0]   wstrb,
    output logic                  wlast,
    output logic                  wvalid,
    input  logic                  wready,
    input  logic [1:0]            bresp,
    input  logic                  bvalid,
    output logic                  bready,
    output logic [ADDR_W-1:0]     araddr,
    output logic [7:0]            arlen,
    output logic [2:0]            arsize,
    output logic [1:0]            arburst,
    output logic                  arvalid,
    input  logic                  arready,
    input  logic [DATA_W-1:0]     rdata,
    input  logic [1:0]            rresp,
    input  logic                  rlast,
    input  logic                  rvalid,
    output logic                  rready
);

    import bcs_pkg::*;

    localparam int BYTES  = DATA_W / 8;
    localparam int SZ     = $clog2(BYTES);
    localparam int BEAT_W = LEN_W - SZ;
    localparam int CNT_W  = $clog2(MAX_BEATS + 1);

    typedef struct packed {
        bcs_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] remain;
        logic              rnw;
        logic              err;
        logic              ack;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [CNT_W-1:0]  ch_cur;
    logic [7:0]        ch_axlen;
    logic [ADDR_W-1:0] ch_next_addr;
    logic [BEAT_W-1:0] ch_next_remain;

    logic load_xfer, load_burst, beat;
    logic burst_last, xfer_first, xfer_last;
    logic in_wdata, in_rdata;

    bcs_chunker #(
        .ADDR_W   (ADDR_W),
        .BEAT_W   (BEAT_W),
        .CNT_W    (CNT_W),
        .MAX_BEATS(MAX_BEATS),
        .SZ       (SZ)
    ) chunk_i (
        .remain     (ctl_q.remain),
        .addr       (ctl_q.addr),
        .cur        (ch_cur),
        .axlen      (ch_axlen),
        .next_addr  (ch_next_addr),
        .next_remain(ch_next_remain)
    );

    bcs_beat_track #(
        .BEAT_W(BEAT_W),
        .CNT_W (CNT_W)
    ) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_xfer  (load_xfer),
        .xfer_beats (BEAT_W'(cmd_len >> SZ)),
        .load_burst (load_burst),
        .burst_beats(ch_cur),
        .beat       (beat),
        .burst_last (burst_last),
        .xfer_first (xfer_first),
        .xfer_last  (xfer_last)
    );

    assign in_wdata = (ctl_q.state == ST_DATA) && !ctl_q.rnw;
    assign in_rdata = (ctl_q.state == ST_DATA) &&  ctl_q.rnw;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.ack  = 1'b0;
        load_xfer  = 1'b0;
        load_burst = 1'b0;
        beat       = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctl_d.addr   = cmd_addr;
                    ctl_d.remain = BEAT_W'(cmd_len >> SZ);
                    ctl_d.rnw    = cmd_rnw;
                    ctl_d.err    = 1'b0;
                    ctl_d.ack    = 1'b1;
                    ctl_d.state  = ST_ADDR;
                    load_xfer    = 1'b1;
                end
            end
            ST_ADDR: begin
                if (ctl_q.rnw ? arready : awready) begin
                    load_burst   = 1'b1;
                    ctl_d.addr   = ch_next_addr;
                    ctl_d.remain = ch_next_remain;
                    ctl_d.state  = ST_DATA;
                end
            end
            ST_DATA: begin
                if (ctl_q.rnw) begin
                    beat = rvalid && rd_ready;
                    if (beat && (rresp != RESP_OKAY)) begin
                        ctl_d.err = 1'b1;
                    end
                    if (beat && rlast) begin
                        ctl_d.state = (ctl_q.remain == '0) ? ST_DONE : ST_ADDR;
                    end
                end else begin
                    beat = wr_valid && wready;
                    if (beat && burst_last) begin
                        ctl_d.state = ST_RESP;
                    end
                end
            end
            ST_RESP: begin
                if (bvalid) begin
                    if (bresp != RESP_OKAY) begin
                        ctl_d.err = 1'b1;
                    end
                    ctl_d.state = (ctl_q.remain == '0) ? ST_DONE : ST_ADDR;
                end
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Address channels
    assign awaddr  = ctl_q.addr;
    assign araddr  = ctl_q.addr;
    assign awlen   = ch_axlen;
    assign arlen   = ch_axlen;
    assign awsize  = 3'(SZ);
    assign arsize  = 3'(SZ);
    assign awburst = BURST_INCR;
    assign arburst = BURST_INCR;
    assign awvalid = (ctl_q.state == ST_ADDR) && !ctl_q.rnw;
    assign arvalid = (ctl_q.state == ST_ADDR) &&  ctl_q.rnw;

    // Write data and response
    assign wdata    = wr_data;
    assign wstrb    = '1;
    assign wvalid   = in_wdata && wr_valid;
    assign wr_ready = in_wdata && wready;
    assign wlast    = in_wdata && burst_last;
    assign wr_sof_n = !(in_wdata && xfer_first);
    assign wr_eof_n = !(in_wdata && xfer_last);
    assign bready   = (ctl_q.state == ST_RESP);

    // Read data
    assign rd_data  = rdata;
    assign rd_valid = in_rdata && rvalid;
    assign rready   = in_rdata && rd_ready;
    assign rd_sof_n = !(in_rdata && xfer_first);
    assign rd_eof_n = !(in_rdata && xfer_last);

    // User command status
    assign cmd_ack  = ctl_q.ack;
    assign cmd_done = (ctl_q.state == ST_DONE);
    assign cmd_err  = (ctl_q.state == ST_DONE) && ctl_q.err;

endmodule

// File: rtl/bcs_checker.sv
`timescale 1ns/1ps
module bcs_checker #(
    parameter int DATA_W    = 32,
    parameter int MAX_BEATS = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_ack,
    input logic        cmd_done,
    input logic        cmd_err,
    input logic        awvalid,
    input logic        awready,
    input logic [31:0] awaddr_lo,
    input logic [7:0]  awlen,
    input logic [2:0]  awsize,
    input logic [1:0]  awburst,
    input logic        arvalid,
    input logic        arready,
    input logic [31:0] araddr_lo,
    input logic [7:0]  arlen,
    input logic        wvalid,
    input logic        bready,
    input logic        rready
);

    localparam int SZ = $clog2(DATA_W / 8);

    assert_ack_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ack |=> !cmd_ack);

    assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid || arvalid) |-> (int'(awlen) < MAX_BEATS && int'(arlen) < MAX_BEATS));

    assert_size_incr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (awsize == 3'(SZ) && awburst == 2'b01));

    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (!wvalid && !bready));

    assert_single_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid |-> !rready);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_done);

    assert_aw_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr_lo) && $stable(awlen)));

    assert_ar_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> (arvalid && $stable(araddr_lo) && $stable(arlen)));

endmodule

bind burst_cmd_splitter bcs_checker #(
    .DATA_W   (DATA_W),
    .MAX_BEATS(MAX_BEATS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ack  (cmd_ack),
    .cmd_done (cmd_done),
    .cmd_err  (cmd_err),
    .awvalid  (awvalid),
    .awready  (awready),
    .awaddr_lo(32'(awaddr)),
    .awlen    (awlen),
    .awsize   (awsize),
    .awburst  (awburst),
    .arvalid  (arvalid),
    .arready  (arready),
    .araddr_lo(32'(araddr)),
    .arlen    (arlen),
    .wvalid   (wvalid),
    .bready   (bready),
    .rready   (rready)
);

// File: tb/burst_cmd_splitter_tb_top.sv
`timescale 1ns/1ps
module burst_cmd_splitter_tb_top;

    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int LW  = 16;
    localparam int MAXB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_rnw = 1'b0;
    logic          cmd_ack, cmd_done, cmd_err;
    logic [DW-1:0] wr_data = '0;
    logic          wr_valid = 1'b0;
    logic          wr_ready, wr_sof_n, wr_eof_n;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic          rd_sof_n, rd_eof_n;
    logic [AW-1:0] awaddr, araddr;
    logic [7:0]    awlen, arlen;
    logic [2:0]    awsize, arsize;
    logic [1:0]    awburst, arburst;
    logic          awvalid, arvalid;
    logic          awready = 1'b0, arready = 1'b0;
    logic [DW-1:0] wdata;
    logic [3:0]    wstrb;
    logic          wlast, wvalid;
    logic          wready = 1'b0;
    logic [1:0]    bresp = 2'b00;
    logic          bvalid = 1'b0;
    logic          bready;
    logic [DW-1:0] rdata = '0;
    logic [1:0]    rresp = 2'b00;
    logic          rlast = 1'b0, rvalid = 1'b0;
    logic          rready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    burst_cmd_splitter #(
        .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .MAX_BEATS(MAXB)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_rnw(cmd_rnw),
        .cmd_ack(cmd_ack), .cmd_done(cmd_done), .cmd_err(cmd_err),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_sof_n(wr_sof_n), .wr_eof_n(wr_eof_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_sof_n(rd_sof_n), .rd_eof_n(rd_eof_n),
        .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
        .awvalid(awvalid), .awready(awready),
        .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
        .bresp(bresp), .bvalid(bvalid), .bready(bready),
        .araddr(araddr), .arlen(arlen), .arsize(arsize), .arburst(arburst),
        .arvalid(arvalid), .arready(arready),
        .rdata(rdata), .rresp(rresp), .rlast(rlast), .rvalid(rvalid), .rready(rready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            summary_and_end();
        end
    end

    // One command against a modelled slave; phase: -1 wait, 0 addr, 1 data, 2 resp, 3 done
    task automatic run_cmd(input logic [31:0] a, input int nbeats, input bit rnw, input int errb);
        int nb, k, beat, g, phase, t, cur_len;
        bit hs;
        nb = (nbeats + MAXB - 1) / MAXB;
        k = 0; beat = 0; g = 0; phase = -1; t = 0;
        @(negedge clk);
        cmd_addr  = a;
        cmd_len   = LW'(nbeats * 4);
        cmd_rnw   = rnw;
        cmd_valid = 1'b1;
        while (phase != 4) begin
            cur_len = (nbeats - k * MAXB > MAXB) ? MAXB : nbeats - k * MAXB;
            if (t == 1) cmd_valid = 1'b0;
            awready  = ((t + k) % 3) != 1;
            arready  = ((t + k) % 3) != 1;
            wr_valid = (t % 4) != 2;
            wr_data  = {a[15:0] ^ 16'(g), 16'(t)};
            wready   = (t % 5) != 3;
            rvalid   = (phase == 1) && rnw && ((t % 3) != 0);
            rdata    = 32'hA500_0000 | 32'(g) | (32'(t) << 12);
            rlast    = (beat == cur_len - 1);
            rresp    = (k == errb && beat == 0) ? 2'b10 : 2'b00;
            rd_ready = (t % 4) != 1;
            bvalid   = (phase == 2) && ((t % 2) == 0);
            bresp    = (k == errb) ? 2'b11 : 2'b00;
            #1;
            chk(cmd_ack == (t == 1), "R1", "cmd_ack", 64'(cmd_ack), 64'(t == 1));
            chk(cmd_done == (phase == 3), "R9", "cmd_done", 64'(cmd_done), 64'(phase == 3));
            if (phase == 3)
                chk(cmd_err == (errb >= 0), "R10", "cmd_err", 64'(cmd_err), 64'(errb >= 0));
            chk(awvalid == (phase == 0 && !rnw), "R5", "awvalid", 64'(awvalid), 64'(phase == 0 && !rnw));
            chk(arvalid == (phase == 0 && rnw), "R5", "arvalid", 64'(arvalid), 64'(phase == 0 && rnw));
            chk(bready == (phase == 2), "R5", "bready", 64'(bready), 64'(phase == 2));
            if (phase == 0) begin
                chk((rnw ? araddr : awaddr) == a + 32'(k * MAXB * 4), "R3", "burst address",
                    64'(rnw ? araddr : awaddr), 64'(a + 32'(k * MAXB * 4)));
                chk(int'(rnw ? arlen : awlen) == cur_len - 1, "R2", "burst length",
                    64'(rnw ? arlen : awlen), 64'(cur_len - 1));
                chk((rnw ? arsize : awsize) == 3'd2 && (rnw ? arburst : awburst) == 2'b01, "R4",
                    "size/burst", 64'({rnw ? arsize : awsize, rnw ? arburst : awburst}), 64'({3'd2, 2'b01}));
            end
            if (!rnw) begin
                chk(wvalid == (phase == 1 && wr_valid), "R8", "wvalid", 64'(wvalid), 64'(phase == 1 && wr_valid));
                chk(wr_ready == (phase == 1 && wready), "R8", "wr_ready", 64'(wr_ready), 64'(phase == 1 && wready));
                chk(rready == 1'b0, "R5", "rready on write", 64'(rready), 64'(0));
                if (phase == 1 && wvalid) begin
                    chk(wdata == wr_data, "R8", "wdata", 64'(wdata), 64'(wr_data));
                    chk(wstrb == 4'hF, "R4", "wstrb", 64'(wstrb), 64'hF);
                    chk(wlast == (beat == cur_len - 1), "R6", "wlast", 64'(wlast), 64'(beat == cur_len - 1));
                    chk(wr_sof_n == (g != 0), "R7", "wr_sof_n", 64'(wr_sof_n), 64'(g != 0));
                    chk(wr_eof_n == (g != nbeats - 1), "R7", "wr_eof_n", 64'(wr_eof_n), 64'(g != nbeats - 1));
                end
            end else begin
                chk(rd_valid == (phase == 1 && rvalid), "R8", "rd_valid", 64'(rd_valid), 64'(phase == 1 && rvalid));
                chk(rready == (phase == 1 && rd_ready), "R8", "rready", 64'(rready), 64'(phase == 1 && rd_ready));
                chk(wvalid == 1'b0, "R5", "wvalid on read", 64'(wvalid), 64'(0));
                if (phase == 1 && rvalid) begin
                    chk(rd_data == rdata, "R8", "rd_data", 64'(rd_data), 64'(rdata));
                    chk(rd_sof_n == (g != 0), "R7", "rd_sof_n", 64'(rd_sof_n), 64'(g != 0));
                    chk(rd_eof_n == (g != nbeats - 1), "R7", "rd_eof_n", 64'(rd_eof_n), 64'(g != nbeats - 1));
                end
            end
            // model the edge that follows
            case (phase)
                -1: phase = 0;
                0: if (rnw ? arready : awready) begin phase = 1; beat = 0; end
                1: begin
                    hs = rnw ? (rvalid && rd_ready) : (wr_valid && wready);
                    if (hs) begin
                        beat++; g++;
                        if (beat == cur_len) begin
                            if (rnw) begin
                                k++;
                                phase = (k == nb) ? 3 : 0;
                            end else begin
                                phase = 2;
                            end
                        end
                    end
                end
                2: if (bvalid) begin k++; phase = (k == nb) ? 3 : 0; end
                3: phase = 4;
                default: phase = 4;
            endcase
            t++;
            if (t > 3000) begin
                chk(1'b0, "R9", "command never completed", 64'(t), 64'(0));
                phase = 4;
            end
            @(negedge clk);
        end
        rvalid = 1'b0;
        bvalid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs quiet under reset
        chk({awvalid, arvalid, wvalid, bready, rready, cmd_ack, cmd_done} == 7'b0, "R11",
            "outputs under reset", 64'({awvalid, arvalid, wvalid, bready, rready, cmd_ack, cmd_done}), 64'(0));
        chk({wr_ready, rd_valid} == 2'b0, "R11", "user handshakes under reset",
            64'({wr_ready, rd_valid}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk({awvalid, arvalid, cmd_ack, cmd_done} == 4'b0, "R11", "idle after reset",
            64'({awvalid, arvalid, cmd_ack, cmd_done}), 64'(0));
        // sweep every beat count up to five bursts, both directions
        for (int rw = 0; rw < 2; rw++) begin
            for (int n = 1; n <= 5 * MAXB; n++) begin
                run_cmd(32'h1000_0000 + 32'(n * 512) + 32'(rw * 32'h10_0000), n, rw[0], -1);
            end
        end
        // error responses on a chosen burst, then a clean command clears the flag (R10)
        run_cmd(32'h2000_0040, 10, 1'b1, 1);
        run_cmd(32'h2000_1000, 9, 1'b0, 0);
        run_cmd(32'h2000_2000, 6, 1'b0, 1);
        run_cmd(32'h2000_3000, 5, 1'b1, -1);
        run_cmd(32'h2000_4000, 7, 1'b0, -1);
        summary_and_end();
    end

endmodule